// File: doc/BRIEF.md
# Integer Execution Unit with Signed-Overflow Flag

This block is the purely combinational integer datapath of a load/store RISC core. In one evaluation it takes two register operands, a 16-bit immediate field, a 5-bit constant shift amount and an operation code, and it returns a 32-bit result together with an overflow flag. The operation code also decides how the immediate is widened: arithmetic and compare forms sign-extend it, and logical forms zero-extend it.

Add and subtract come in trapping and non-trapping forms. Both forms produce the same bits, but only the trapping forms can raise the flag. The flag is gated by a valid input, so an idle slot or a non-trapping operation never reports overflow. The block does not vector to a handler. It only raises the flag, and the surrounding pipeline decides what to do with it.

Top module: `alu_int_core`

## Requirements
- R1: ADD(0), ADDU(1), ADDI(10) and ADDIU(11) return A plus the second operand, modulo 2^32. The second operand is B for the register forms and the sign-extended immediate for the immediate forms.
- R2: SUB(2) and SUBU(3) return A minus B, modulo 2^32.
- R3: `ovf_o` is 1 exactly when `valid_i` is 1, the operation is ADD, ADDI or SUB, and the true signed result lies outside -2^31..2^31-1. It is 0 for every other operation, and it is 0 whenever `valid_i` is 0. `valid_i` has no effect on `result_o`.
- R4: SLT(4) and SLTI(12) return 1 when A is less than the second operand as signed two's-complement values, and 0 otherwise. SLTU(5) and SLTIU(13) make the same comparison on unsigned values. The immediate forms sign-extend the immediate.
- R5: AND(6), OR(7), XOR(8) and NOR(9) apply the bitwise function to A and B; NOR(0xFF00FF00, 0xF0F0F0F0) = 0x000F000F.
- R6: ANDI(14), ORI(15) and XORI(16) apply their function to A and the zero-extended immediate, so ORI with 0xFACE changes only bits 15:0.
- R7: LUI(17) returns the immediate in bits 31:16 and zeros in bits 15:0, and it ignores A and B.
- R8: SLL(18), SRL(19) and SRA(20) shift B by `shamt_i`. SLL and SRL fill the vacated bits with zeros, and SRA fills them with copies of bit 31.
- R9: SLLV(21), SRLV(22) and SRAV(23) shift B in the same way, by A modulo 32 (bits 4:0 of A only).
- R10: Codes 24 to 31 return a result of 0 and a flag of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | Operand A; supplies the shift amount for the variable shifts |
| b_i | input | 32 | Operand B; the value that the shift operations shift |
| imm_i | input | 16 | Immediate field, widened according to the operation |
| shamt_i | input | 5 | Constant shift amount |
| op_i | input | 5 | Operation code (values listed in the requirements) |
| valid_i | input | 1 | Qualifies the overflow flag |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed-overflow flag for the trapping add and subtract |

## Verification
Both the result and the flag settle in the same cycle as the inputs, with no register anywhere on the path, so each one is due zero cycles after its stimulus. The bench changes the inputs on a falling clock edge and samples 1 ns later, well before the next rising edge. It then compares against values it works out in 64-bit arithmetic. The sweep crosses every operation code with the corner operands, with immediate and shift amounts paired with them, and then repeats the comparison with random operands.

// File: rtl/alu_int_pkg.sv
package alu_int_pkg;

   typedef enum logic [4:0] {
      OP_ADD   = 5'd0,
      OP_ADDU  = 5'd1,
      OP_SUB   = 5'd2,
      OP_SUBU  = 5'd3,
      OP_SLT   = 5'd4,
      OP_SLTU  = 5'd5,
      OP_AND   = 5'd6,
      OP_OR    = 5'd7,
      OP_XOR   = 5'd8,
      OP_NOR   = 5'd9,
      OP_ADDI  = 5'd10,
      OP_ADDIU = 5'd11,
      OP_SLTI  = 5'd12,
      OP_SLTIU = 5'd13,
      OP_ANDI  = 5'd14,
      OP_ORI   = 5'd15,
      OP_XORI  = 5'd16,
      OP_LUI   = 5'd17,
      OP_SLL   = 5'd18,
      OP_SRL   = 5'd19,
      OP_SRA   = 5'd20,
      OP_SLLV  = 5'd21,
      OP_SRLV  = 5'd22,
      OP_SRAV  = 5'd23
   } alu_op_e;

   typedef enum logic [2:0] {
      U_NONE, U_ARITH, U_CMP, U_LOGIC, U_SHIFT, U_LUI
   } unit_e;

   typedef enum logic [1:0] {
      B_REG, B_SEXT, B_ZEXT
   } bsrc_e;

   typedef enum logic [1:0] {
      L_AND, L_OR, L_XOR, L_NOR
   } lfn_e;

   typedef struct packed {
      unit_e unit;
      bsrc_e bsrc;
      logic  sub;
      logic  trap;
      logic  cmp_signed;
      lfn_e  lfn;
      logic  sh_left;
      logic  sh_arith;
      logic  sh_var;
   } alu_ctl_t;

   function automatic alu_ctl_t alu_decode(logic [4:0] op);
      alu_ctl_t c;
      c = '{unit: U_NONE, bsrc: B_REG, sub: 1'b0, trap: 1'b0,
            cmp_signed: 1'b0, lfn: L_AND, sh_left: 1'b0,
            sh_arith: 1'b0, sh_var: 1'b0};
      case (op)
         OP_ADD:   begin c.unit = U_ARITH; c.trap = 1'b1; end
         OP_ADDU:  c.unit = U_ARITH;
         OP_SUB:   begin c.unit = U_ARITH; c.sub = 1'b1; c.trap = 1'b1; end
         OP_SUBU:  begin c.unit = U_ARITH; c.sub = 1'b1; end
         OP_SLT:   begin c.unit = U_CMP; c.sub = 1'b1; c.cmp_signed = 1'b1; end
         OP_SLTU:  begin c.unit = U_CMP; c.sub = 1'b1; end
         OP_AND:   begin c.unit = U_LOGIC; c.lfn = L_AND; end
         OP_OR:    begin c.unit = U_LOGIC; c.lfn = L_OR; end
         OP_XOR:   begin c.unit = U_LOGIC; c.lfn = L_XOR; end
         OP_NOR:   begin c.unit = U_LOGIC; c.lfn = L_NOR; end
         OP_ADDI:  begin c.unit = U_ARITH; c.bsrc = B_SEXT; c.trap = 1'b1; end
         OP_ADDIU: begin c.unit = U_ARITH; c.bsrc = B_SEXT; end
         OP_SLTI:  begin c.unit = U_CMP; c.bsrc = B_SEXT; c.sub = 1'b1;
                         c.cmp_signed = 1'b1; end
         OP_SLTIU: begin c.unit = U_CMP; c.bsrc = B_SEXT; c.sub = 1'b1; end
         OP_ANDI:  begin c.unit = U_LOGIC; c.bsrc = B_ZEXT; c.lfn = L_AND; end
         OP_ORI:   begin c.unit = U_LOGIC; c.bsrc = B_ZEXT; c.lfn = L_OR; end
         OP_XORI:  begin c.unit = U_LOGIC; c.bsrc = B_ZEXT; c.lfn = L_XOR; end
         OP_LUI:   c.unit = U_LUI;
         OP_SLL:   begin c.unit = U_SHIFT; c.sh_left = 1'b1; end
         OP_SRL:   c.unit = U_SHIFT;
         OP_SRA:   begin c.unit = U_SHIFT; c.sh_arith = 1'b1; end
         OP_SLLV:  begin c.unit = U_SHIFT; c.sh_left = 1'b1; c.sh_var = 1'b1; end
         OP_SRLV:  begin c.unit = U_SHIFT; c.sh_var = 1'b1; end
         OP_SRAV:  begin c.unit = U_SHIFT; c.sh_arith = 1'b1; c.sh_var = 1'b1; end
         default:  c.unit = U_NONE;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel
   import alu_int_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic [DATA_W-1:0] b_reg_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  bsrc_e             bsrc_i,
   output logic [DATA_W-1:0] b_op_o,
   output logic [DATA_W-1:0] upper_o
);
   localparam int EXT_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] imm_sx;
   logic [DATA_W-1:0] imm_zx;

   assign imm_sx  = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
   assign imm_zx  = {{EXT_W{1'b0}}, imm_i};
   assign upper_o = {imm_i, {EXT_W{1'b0}}};

   always_comb begin
      case (bsrc_i)
         B_SEXT:  b_op_o = imm_sx;
         B_ZEXT:  b_op_o = imm_zx;
         default: b_op_o = b_reg_i;
      endcase
   end

   always_comb begin
      if (bsrc_i == B_ZEXT)
         assert_zext_upper_clear_R6: assert (b_op_o[DATA_W-1:IMM_W] == '0);
      if (bsrc_i == B_SEXT)
         assert_sext_matches_sign_R1: assert (b_op_o[DATA_W-1:IMM_W] == '0 ||
                                              b_op_o[DATA_W-1:IMM_W] == '1);
   end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              carry_o,
   output logic              ovf_o
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] b_eff;
   logic [DATA_W:0]   wide;

   assign b_eff   = sub_i ? ~b_i : b_i;
   assign wide    = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
   assign sum_o   = wide[DATA_W-1:0];
   assign carry_o = wide[DATA_W];
   assign ovf_o   = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);

   always_comb begin
      if (!sub_i)
         assert_add_inverse_R1: assert ((sum_o - b_i) == a_i);
      else
         assert_sub_inverse_R2: assert ((sum_o + b_i) == a_i);
   end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
   import alu_int_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  lfn_e              fn_i,
   output logic [DATA_W-1:0] res_o
);
   always_comb begin
      case (fn_i)
         L_AND:   res_o = a_i & b_i;
         L_OR:    res_o = a_i | b_i;
         L_XOR:   res_o = a_i ^ b_i;
         default: res_o = ~(a_i | b_i);
      endcase
   end

   always_comb begin
      if (fn_i == L_NOR) begin
         assert_nor_disjoint_R5: assert ((res_o & (a_i | b_i)) == '0);
         assert_nor_covers_R5:   assert ((res_o | a_i | b_i) == '1);
      end
   end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
   parameter int DATA_W = 32,
   parameter bit STAGED = 1'b1,
   localparam int SH_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] val_i,
   input  logic [SH_W-1:0]   amt_i,
   input  logic              left_i,
   input  logic              arith_i,
   output logic [DATA_W-1:0] res_o
);
   logic fill;
   assign fill = arith_i & val_i[DATA_W-1];

   if (STAGED) begin : g_staged
      always_comb begin
         logic [DATA_W-1:0] x;
         x = val_i;
         for (int k = 0; k < SH_W; k++) begin
            if (amt_i[k]) begin
               if (left_i)
                  x = x << (1 << k);
               else
                  x = (x >> (1 << k)) | ({DATA_W{fill}} & ~({DATA_W{1'b1}} >> (1 << k)));
            end
         end
         res_o = x;
      end
   end else begin : g_operator
      always_comb begin
         if (left_i)
            res_o = val_i << amt_i;
         else if (arith_i)
            res_o = $unsigned($signed(val_i) >>> amt_i);
         else
            res_o = val_i >> amt_i;
      end
   end

   logic [DATA_W-1:0] low_mask;
   logic [DATA_W-1:0] high_mask;
   assign low_mask  = ~({DATA_W{1'b1}} << amt_i);
   assign high_mask = ~({DATA_W{1'b1}} >> amt_i);

   // R9 shares these fill rules; only the amount source differs.
   always_comb begin
      if (left_i)
         assert_left_zero_fill_R8: assert ((res_o & low_mask) == '0);
      else if (!fill)
         assert_right_zero_fill_R8: assert ((res_o & high_mask) == '0);
      else
         assert_right_sign_fill_R8: assert ((res_o & high_mask) == high_mask);
   end
endmodule

// File: rtl/alu_int_core.sv
module alu_int_core
   import alu_int_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int IMM_W         = 16,
   parameter bit STAGED_SHIFT  = 1'b1,
   localparam int SH_W         = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [SH_W-1:0]   shamt_i,
   input  logic [4:0]        op_i,
   input  logic              valid_i,
   output logic [DATA_W-1:0] result_o,
   output logic              ovf_o
);
   if (DATA_W != (1 << SH_W)) begin : g_bad_width
      $error("DATA_W must be a power of two");
   end
   if (IMM_W >= DATA_W) begin : g_bad_imm
      $error("IMM_W must be narrower than DATA_W");
   end

   alu_ctl_t          ctl;
   logic [DATA_W-1:0] b_op;
   logic [DATA_W-1:0] upper;
   logic [DATA_W-1:0] sum;
   logic              carry;
   logic              ovf_raw;
   logic [DATA_W-1:0] logic_res;
   logic [DATA_W-1:0] shift_res;
   logic [SH_W-1:0]   sh_amt;
   logic              less;

   assign ctl    = alu_decode(op_i);
   assign sh_amt = ctl.sh_var ? a_i[SH_W-1:0] : shamt_i;

   alu_opnd_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) opnd_i (
      .b_reg_i (b_i),
      .imm_i   (imm_i),
      .bsrc_i  (ctl.bsrc),
      .b_op_o  (b_op),
      .upper_o (upper)
   );

   alu_addsub #(.DATA_W(DATA_W)) addsub_i (
      .a_i     (a_i),
      .b_i     (b_op),
      .sub_i   (ctl.sub),
      .sum_o   (sum),
      .carry_o (carry),
      .ovf_o   (ovf_raw)
   );

   alu_logic #(.DATA_W(DATA_W)) logic_i (
      .a_i   (a_i),
      .b_i   (b_op),
      .fn_i  (ctl.lfn),
      .res_o (logic_res)
   );

   alu_shifter #(.DATA_W(DATA_W), .STAGED(STAGED_SHIFT)) shift_i (
      .val_i   (b_i),
      .amt_i   (sh_amt),
      .left_i  (ctl.sh_left),
      .arith_i (ctl.sh_arith),
      .res_o   (shift_res)
   );

   // Signed: sign of the difference corrected by overflow; unsigned: borrow.
   assign less = ctl.cmp_signed ? (sum[DATA_W-1] ^ ovf_raw) : ~carry;

   always_comb begin
      case (ctl.unit)
         U_ARITH: result_o = sum;
         U_CMP:   result_o = {{(DATA_W-1){1'b0}}, less};
         U_LOGIC: result_o = logic_res;
         U_SHIFT: result_o = shift_res;
         U_LUI:   result_o = upper;
         default: result_o = '0;
      endcase
   end

   assign ovf_o = valid_i & ctl.trap & ovf_raw;

   always_comb begin
      if (!valid_i || !ctl.trap)
         assert_no_overflow_R3: assert (!ovf_o);
      if (ctl.unit == U_CMP) begin
         assert_cmp_boolean_R4: assert (result_o[DATA_W-1:1] == '0);
         if (ctl.cmp_signed)
            assert_cmp_signed_R4: assert (result_o[0] == ($signed(a_i) < $signed(b_op)));
         else
            assert_cmp_unsigned_R4: assert (result_o[0] == (a_i < b_op));
      end
      if (ctl.unit == U_LUI)
         assert_lui_low_clear_R7: assert (result_o[DATA_W-IMM_W-1:0] == '0);
      if (op_i > 5'd23)
         assert_undef_quiet_R10: assert (result_o == '0 && !ovf_o);
   end
endmodule

// File: tb/alu_int_core_tb.sv
module alu_int_core_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] a, b;
   logic [15:0] imm;
   logic [4:0]  shamt;
   logic [4:0]  op;
   logic        valid;
   logic [31:0] result;
   logic        ovf;

   int checks   = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   alu_int_core dut_i (
      .a_i(a), .b_i(b), .imm_i(imm), .shamt_i(shamt), .op_i(op),
      .valid_i(valid), .result_o(result), .ovf_o(ovf)
   );

   function automatic string req_of(int o);
      case (o)
         0, 1, 10, 11: return "R1";
         2, 3:         return "R2";
         4, 5, 12, 13: return "R4";
         6, 7, 8, 9:   return "R5";
         14, 15, 16:   return "R6";
         17:           return "R7";
         18, 19, 20:   return "R8";
         21, 22, 23:   return "R9";
         default:      return "R10";
      endcase
   endfunction

   function automatic logic [31:0] shr_arith(logic [31:0] x, int n);
      if (x[31]) return ~((~x) >> n);
      return x >> n;
   endfunction

   function automatic logic [32:0] model(int o, logic [31:0] x, logic [31:0] y,
                                         logic [15:0] im, logic [4:0] sa, logic v);
      logic [31:0] sx, zx, r, opb;
      longint      s, lim_hi, lim_lo;
      logic        f;
      sx = {{16{im[15]}}, im};
      zx = {16'h0, im};
      f = 1'b0;
      r = 32'h0;
      lim_hi = 64'sd2147483647;
      lim_lo = -64'sd2147483648;
      opb = (o >= 10 && o <= 13) ? sx : y;
      case (o)
         0, 1, 10, 11: begin
            s = longint'($signed(x)) + longint'($signed(opb));
            r = x + opb;
            f = (o == 0 || o == 10) && (s > lim_hi || s < lim_lo);
         end
         2, 3: begin
            s = longint'($signed(x)) - longint'($signed(y));
            r = x - y;
            f = (o == 2) && (s > lim_hi || s < lim_lo);
         end
         4, 12: r = (longint'($signed(x)) < longint'($signed(opb))) ? 32'd1 : 32'd0;
         5, 13: r = ({32'h0, x} < {32'h0, opb}) ? 32'd1 : 32'd0;
         6:  r = x & y;
         7:  r = x | y;
         8:  r = x ^ y;
         9:  r = ~(x | y);
         14: r = x & zx;
         15: r = x | zx;
         16: r = x ^ zx;
         17: r = {im, 16'h0};
         18: r = y << sa;
         19: r = y >> sa;
         20: r = shr_arith(y, int'(sa));
         21: r = y << x[4:0];
         22: r = y >> x[4:0];
         23: r = shr_arith(y, int'(x[4:0]));
         default: r = 32'h0;
      endcase
      return {f & v, r};
   endfunction

   task automatic run(int o, logic [31:0] x, logic [31:0] y,
                      logic [15:0] im, logic [4:0] sa, logic v, string note);
      logic [32:0] exp_v;
      @(negedge clk);
      op = o[4:0]; a = x; b = y; imm = im; shamt = sa; valid = v;
      #1;
      exp_v = model(o, x, y, im, sa, v);
      checks++;
      if (result !== exp_v[31:0]) begin
         failures++;
         $display("FAIL %s %s op=%0d result actual=%h expected=%h",
                  req_of(o), note, o, result, exp_v[31:0]);
      end
      checks++;
      if (ovf !== exp_v[32]) begin
         failures++;
         $display("FAIL R3 %s op=%0d ovf actual=%b expected=%b", note, o, ovf, exp_v[32]);
      end
   endtask

   task automatic expect_val(string req, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   initial begin
      logic [31:0] corners [7];
      logic [15:0] imms [6];
      logic [4:0]  shs [6];
      corners = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000,
                  32'hFFFF_FFFF, 32'hFF00_FF00, 32'hF0F0_F0F0};
      imms = '{16'h0, 16'h1, 16'h7FFF, 16'h8000, 16'hFFFF, 16'hFACE};
      shs  = '{5'd0, 5'd1, 5'd31, 5'd16, 5'd5, 5'd7};
      op = 5'd0; a = 32'h7FFF_FFFF; b = 32'h1; imm = 16'h0; shamt = 5'd0; valid = 1'b0;

      // Reset: valid low, an overflowing ADD must leave the flag low (R3).
      repeat (3) @(posedge clk);
      @(negedge clk);
      expect_val("R3 reset flag", {31'h0, ovf}, 32'h0);
      expect_val("R1 reset sum", result, 32'h8000_0000);
      rst = 1'b0;

      // Directed cases.
      run(9,  32'hFF00_FF00, 32'hF0F0_F0F0, 16'h0, 5'd0, 1'b1, "R5 nor example");
      expect_val("R5 nor example value", result, 32'h000F_000F);
      run(15, 32'h1234_0000, 32'hDEAD_BEEF, 16'hFACE, 5'd0, 1'b1, "R6 ori");
      expect_val("R6 ori high half kept", result, 32'h1234_FACE);
      run(17, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hC0DE, 5'd0, 1'b1, "R7 lui");
      expect_val("R7 lui value", result, 32'hC0DE_0000);
      run(0,  32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, 1'b1, "R3 add overflow");
      expect_val("R3 add flag", {31'h0, ovf}, 32'h1);
      run(1,  32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, 1'b1, "R3 addu no flag");
      expect_val("R3 addu flag", {31'h0, ovf}, 32'h0);
      run(2,  32'h8000_0000, 32'h1, 16'h0, 5'd0, 1'b0, "R3 sub valid low");
      expect_val("R3 sub valid low flag", {31'h0, ovf}, 32'h0);
      run(10, 32'h8000_0000, 32'h0, 16'hFFFF, 5'd0, 1'b1, "R3 addi negative overflow");
      expect_val("R3 addi flag", {31'h0, ovf}, 32'h1);
      run(21, 32'hFFFF_FFE3, 32'h1, 16'h0, 5'd9, 1'b1, "R9 amount modulo 32");
      expect_val("R9 sllv by low bits", result, 32'h0000_0008);
      run(20, 32'h0, 32'h8000_0000, 16'h0, 5'd31, 1'b1, "R8 sra full");
      expect_val("R8 sra sign fill", result, 32'hFFFF_FFFF);
      run(13, 32'h0000_0005, 32'h0, 16'hFFFF, 5'd0, 1'b1, "R4 sltiu sign-extended");
      expect_val("R4 sltiu", result, 32'h1);
      run(27, 32'h7FFF_FFFF, 32'h1, 16'hFFFF, 5'd3, 1'b1, "R10 undefined");

      // Sweep: all codes x corner operands, immediate/shift paired.
      for (int o = 0; o < 32; o++)
         for (int i = 0; i < 7; i++)
            for (int j = 0; j < 7; j++)
               for (int k = 0; k < 6; k++)
                  run(o, corners[i], corners[j], imms[k], shs[k], 1'b1, "sweep");

      // Random operands for every code, valid toggled.
      for (int n = 0; n < 4000; n++)
         run(n % 32, $urandom, $urandom, 16'($urandom), 5'($urandom),
             1'(n % 7 != 0), "random");

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(4 * 190000);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule